// File: doc/BRIEF.md
# Double-Buffered Split-Write DAC Register

This block is the digital front end of a 12-bit digital-to-analog converter, modelled synchronously. A host writes a 12-bit code over a shared 8-bit bus in two parts. The low byte goes in under one active-low select, and the upper four bits go in under a second select. Both parts need the active-low write strobe. The assembled word sits in an input register until an active-low load strobe copies it into the DAC register, which drives the output code. Every level-sensitive latch is modelled as a register that follows its data while its enable is active and holds when the enable drops.

The load strobe may be low during a write, so a high-part write and the transfer can happen in one operation. Tying the load strobe to one select gives an automatic two-write update. When the load strobe overlaps a write, it must stay low for `HOLD_CYC` cycles after the write ends. A small state machine checks this with three states: `HS_IDLE` (no overlap), `HS_OVERLAP` (write and load both active) and `HS_HOLD` (write ended, load still low, counting). Its transitions are:

- `HS_IDLE` to `HS_OVERLAP` when write and load are both active.
- `HS_OVERLAP` to `HS_HOLD` when the write ends with load still low.
- `HS_OVERLAP` to `HS_IDLE` when load rises, which flags a violation.
- `HS_HOLD` to `HS_IDLE` when the count is met.
- `HS_HOLD` to `HS_IDLE` when load rises early, which flags a violation.
- `HS_HOLD` back to `HS_OVERLAP` when a new write starts.

The bus data and all strobes pass through a two-stage synchronizer before use.

Top module: `dbl_dac_reg`

## Requirements
- R1: With the low select and the write strobe both low, `bus_data[7:0]` is loaded into bits [7:0] of the input register.
- R2: With the high select and the write strobe both low, `bus_data[3:0]` is loaded into bits [11:8] of the input register, and `bus_data[7:4]` is ignored.
- R3: Input register contents stay frozen once the write strobe or the relevant select is high, whatever the bus carries.
- R4: While the load strobe is low, the DAC register follows the input register. While the load strobe is high, the DAC register holds.
- R5: With high select, write and load all low, the nibble enters the input register and the complete 12-bit word reaches `dac_code` in the same operation.
- R6: If the load strobe is low during an active write, it must stay low for at least `HOLD_CYC` (default 3) cycles after the write ends. Otherwise `hold_viol` pulses high for one cycle.
- R7: With the high select tied to the load strobe, a low-byte write followed by a high-part write updates `dac_code` in two bus writes. With the low select tied to the load strobe, a high-part write followed by a low-byte write does the same.
- R8: With both selects high and the load strobe high, neither register changes.
- R9: An input change at the pins reaches `dac_code` on the third rising clock edge after it is applied, because of the two synchronizer stages.
- R10: A synchronous active-high `rst` clears both registers and all output flags to zero.
- R11: `dac_upd` is high for exactly one cycle, and in exactly the cycles where `dac_code` has just taken a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Shared write data bus |
| lo_sel_n | input | 1 | Low-byte select, active low |
| hi_sel_n | input | 1 | High-part select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load-DAC strobe, active low |
| dac_code | output | 12 | DAC register contents |
| dac_upd | output | 1 | One-cycle pulse when `dac_code` changes |
| hold_viol | output | 1 | One-cycle pulse on a load-hold violation |

## Verification
The hardest case to reach from the pins is the hold boundary. The load strobe has to overlap a write and then be released a set number of cycles after the write strobe rises. Only the relative timing of the two pin edges matters, because both cross the same synchronizer. The bench therefore releases the write strobe and then raises the load strobe after zero, one and exactly `HOLD_CYC` cycles. It expects a violation pulse for the first two and none for the third. Tied-strobe sequences in both orders are driven the same way: the write strobe is released first and the tied pair after the hold window, so the automatic update raises no flag.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    typedef struct packed {
        logic lo_n;
        logic hi_n;
        logic wr_n;
        logic ld_n;
    } strobe_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_OVERLAP,
        HS_HOLD
    } hold_state_e;

endpackage

// File: rtl/dacreg_sync.sv
module dacreg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacreg_input.sv
module dacreg_input #(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  data,
    input  logic              lo_en,
    input  logic              hi_en,
    output logic [CODE_W-1:0] in_q,
    output logic [CODE_W-1:0] in_nxt
);
    localparam int HI_W = CODE_W - BUS_W;

    always_comb begin
        in_nxt = in_q;
        if (lo_en) in_nxt[BUS_W-1:0]      = data;
        if (hi_en) in_nxt[CODE_W-1:BUS_W] = data[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= in_nxt;
    end
endmodule

// File: rtl/dacreg_output.sv
module dacreg_output #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [CODE_W-1:0] in_nxt,
    output logic [CODE_W-1:0] dac_q,
    output logic              upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (ld_en) begin
                dac_q <= in_nxt;
                upd   <= (in_nxt != dac_q);
            end
        end
    end
endmodule

// File: rtl/dacreg_hold_mon.sv
module dacreg_hold_mon
    import dacreg_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_act,
    input  logic ld_act,
    output logic hold_viol
);
    localparam int CW = $clog2(HOLD_CYC + 1) < 1 ? 1 : $clog2(HOLD_CYC + 1);

    hold_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          viol_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        viol_d = 1'b0;
        unique case (st_q)
            HS_IDLE: begin
                if (wr_act && ld_act) st_d = HS_OVERLAP;
            end
            HS_OVERLAP: begin
                if (!ld_act) begin
                    viol_d = 1'b1;
                    st_d   = HS_IDLE;
                end else if (!wr_act) begin
                    if (HOLD_CYC <= 1) begin
                        st_d = HS_IDLE;
                    end else begin
                        st_d  = HS_HOLD;
                        cnt_d = CW'(1);
                    end
                end
            end
            HS_HOLD: begin
                if (!ld_act) begin
                    viol_d = 1'b1;
                    st_d   = HS_IDLE;
                end else if (wr_act) begin
                    st_d = HS_OVERLAP;
                end else if ((cnt_q + CW'(1)) >= CW'(HOLD_CYC)) begin
                    st_d = HS_IDLE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: st_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hold_viol <= 1'b0;
        else     hold_viol <= viol_d;
    end
endmodule

// File: rtl/dbl_dac_reg.sv
module dbl_dac_reg
    import dacreg_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int CODE_W   = 12,
    parameter int SYNC_STG = 2,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              lo_sel_n,
    input  logic              hi_sel_n,
    input  logic              wr_n,
    input  logic              ld_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_upd,
    output logic              hold_viol
);
    localparam int STB_W = $bits(strobe_t);

    strobe_t           strb_raw, strb_s;
    logic [BUS_W-1:0]  data_s;
    logic [CODE_W-1:0] in_q, in_nxt;
    logic              lo_en, hi_en, wr_act, ld_act;

    assign strb_raw = '{lo_n: lo_sel_n, hi_n: hi_sel_n, wr_n: wr_n, ld_n: ld_n};

    dacreg_sync #(.W(STB_W), .STAGES(SYNC_STG), .RST_VAL({STB_W{1'b1}})) u_sync_stb (
        .clk (clk),
        .rst (rst),
        .d   (strb_raw),
        .q   (strb_s)
    );

    dacreg_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL('0)) u_sync_dat (
        .clk (clk),
        .rst (rst),
        .d   (bus_data),
        .q   (data_s)
    );

    assign lo_en  = !strb_s.lo_n && !strb_s.wr_n;
    assign hi_en  = !strb_s.hi_n && !strb_s.wr_n;
    assign wr_act = lo_en || hi_en;
    assign ld_act = !strb_s.ld_n;

    dacreg_input #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_input (
        .clk    (clk),
        .rst    (rst),
        .data   (data_s),
        .lo_en  (lo_en),
        .hi_en  (hi_en),
        .in_q   (in_q),
        .in_nxt (in_nxt)
    );

    dacreg_output #(.CODE_W(CODE_W)) u_output (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_act),
        .in_nxt (in_nxt),
        .dac_q  (dac_code),
        .upd    (dac_upd)
    );

    dacreg_hold_mon #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_act    (wr_act),
        .ld_act    (ld_act),
        .hold_viol (hold_viol)
    );
endmodule

// File: rtl/dacreg_checker.sv
module dacreg_checker
    import dacreg_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_upd,
    input logic              hold_viol,
    input strobe_t           strb_s,
    input logic [BUS_W-1:0]  data_s,
    input logic [CODE_W-1:0] in_q
);
    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        dac_upd |-> (dac_code != $past(dac_code))); // R11

    AST_QUIET_MEANS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !dac_upd |-> $stable(dac_code)); // R11

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && !dac_upd && !hold_viol)); // R10

    AST_VIOL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hold_viol |=> !hold_viol); // R6

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (strb_s.lo_n && strb_s.hi_n && strb_s.ld_n) |=> ($stable(in_q) && $stable(dac_code))); // R8

    AST_LOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!strb_s.lo_n && !strb_s.wr_n) |=> (in_q[BUS_W-1:0] == $past(data_s))); // R1

    AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!strb_s.hi_n && !strb_s.wr_n) |=> (in_q[CODE_W-1:BUS_W] == $past(data_s[CODE_W-BUS_W-1:0]))); // R2
endmodule

bind dbl_dac_reg dacreg_checker #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_code  (dac_code),
    .dac_upd   (dac_upd),
    .hold_viol (hold_viol),
    .strb_s    (strb_s),
    .data_s    (data_s),
    .in_q      (in_q)
);

// File: tb/dbl_dac_reg_test.sv
`timescale 1ns/1ps
module dbl_dac_reg_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_data = 8'h00;
    logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
    logic [11:0] dac_code;
    logic        dac_upd, hold_viol;

    int checks = 0, fails = 0, viol_seen = 0;
    logic [11:0] exp_q[$];

    always #2.5 clk = ~clk;

    dbl_dac_reg uut (
        .clk(clk), .rst(rst), .bus_data(bus_data), .lo_sel_n(lo_sel_n),
        .hi_sel_n(hi_sel_n), .wr_n(wr_n), .ld_n(ld_n),
        .dac_code(dac_code), .dac_upd(dac_upd), .hold_viol(hold_viol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic lo, input logic hi, input logic wr, input logic ld, input logic [7:0] d);
        @(negedge clk);
        lo_sel_n = lo; hi_sel_n = hi; wr_n = wr; ld_n = ld; bus_data = d;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: scoreboard for DAC updates and hold-flag counting
    always @(negedge clk) begin
        if (!rst) begin
            if (dac_upd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected update", dac_code, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check(dac_code == e, "R4/R11 update value", dac_code, e);
                end
            end
            if (hold_viol) viol_seen++;
        end
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(dac_code == 12'h000 && !dac_upd && !hold_viol, "R10 reset state", dac_code, 0);
        rst = 1'b0;
        idle_wait(4);

        // R1: low byte write with load high, no DAC change
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'hA5);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);
        check(dac_code == 12'h000, "R4 hold while load high", dac_code, 0);

        // R4 + R9: load alone, latency of three edges
        exp_q.push_back(12'h0A5);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        idle_wait(2);
        check(dac_code == 12'h000, "R9 not yet after two edges", dac_code, 0);
        idle_wait(1);
        check(dac_code == 12'h0A5, "R9 R1 visible on third edge", dac_code, 12'h0A5);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);

        // R2 + R3: high part uses data[3:0]; frozen afterwards
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hF7);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'hF7);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h3E);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        exp_q.push_back(12'h7A5);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);
        check(dac_code == 12'h7A5, "R2 R3 high part and freeze", dac_code, 12'h7A5);

        // R5 + R7: high select tied to load, byte then nibble
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C);
        idle_wait(5);
        check(dac_code == 12'h7A5, "R7 first write leaves output", dac_code, 12'h7A5);
        exp_q.push_back(12'h93C);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h09);
        idle_wait(2);
        drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h09);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);
        check(dac_code == 12'h93C, "R5 R7 tied high-select update", dac_code, 12'h93C);

        // R7: low select tied to load, nibble then byte
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h02);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h02);
        idle_wait(5);
        exp_q.push_back(12'h211);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h11);
        idle_wait(2);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h11);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);
        check(dac_code == 12'h211, "R7 tied low-select update", dac_code, 12'h211);
        check(viol_seen == 0, "R6 no flag on correct hold", viol_seen, 0);

        // R8: no select, no load: nothing changes; then a load shows input unchanged
        drive(1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
        idle_wait(4);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(4);
        check(dac_code == 12'h211, "R8 idle leaves output", dac_code, 12'h211);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(5);
        check(dac_code == 12'h211, "R8 input register unchanged", dac_code, 12'h211);

        // R6: release together -> violation
        exp_q.push_back(12'h255);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h55);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(6);
        check(viol_seen == 1, "R6 simultaneous release flagged", viol_seen, 1);

        // R6: load held only one cycle after write -> violation
        exp_q.push_back(12'h266);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h66);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h66);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(6);
        check(viol_seen == 2, "R6 short hold flagged", viol_seen, 2);

        // R6: load held exactly HOLD_CYC cycles -> no violation
        exp_q.push_back(12'h277);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h77);
        idle_wait(3);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h77);
        idle_wait(2);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(6);
        check(viol_seen == 2, "R6 exact hold accepted", viol_seen, 2);
        check(dac_code == 12'h277, "R4 follow during load", dac_code, 12'h277);
        check(exp_q.size() == 0, "R11 all updates seen", exp_q.size(), 0);

        // R10: reset mid-run
        @(negedge clk); rst = 1'b1;
        idle_wait(2);
        check(dac_code == 12'h000 && !dac_upd, "R10 reset clears", dac_code, 0);
        rst = 1'b0;
        idle_wait(4);
        exp_q.push_back(12'h000);
        exp_q.delete();
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        idle_wait(4);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        idle_wait(3);
        check(dac_code == 12'h000, "R10 input register cleared", dac_code, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule